// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh

This block sits between a synchronous host and an asynchronous page-mode DRAM. The host offers one word access at a time over a valid/ready handshake. The controller splits the word address into a row part and a column part and sends both over one shared address bus. The row goes out under a falling row strobe and the column under a falling column strobe. Writes are strobed with the write enable low. Reads are strobed with the output enable low, and the returned word comes back to the host as a single-cycle valid pulse.

After an access the row stays open. A later access to the same row needs only a fresh column pulse. An access to another row first closes the page by precharging, then opens the new row.

A free-running interval timer requests one CAS-before-RAS refresh every `REF_WINDOW >> ROW_W` cycles. This gives 1,024 refreshes per window for 10-bit rows and 2,048 for 11-bit rows. The refresh wins at the next point where the sequencer is idle. All timing is expressed as clock-cycle counts set by parameters. For example, a 20 ns page cycle at 100 MHz becomes a two-cycle column pulse.

Top module: `dram_pm_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, all four strobes are high and no row counts as open, so the first access after reset always activates a row.
- R2: The row is bits [ROW_W+COL_W-1:COL_W] of `req_addr` and appears on `dram_addr` in the cycle where `ras_n` falls. The column is bits [COL_W-1:0] and appears on `dram_addr` in the cycle where `cas_n` falls.
- R3: An access to the row that is already open produces no new row strobe. `ras_n` stays low and only a new column pulse is issued.
- R4: An access to a different row raises `ras_n` for exactly `T_RP` cycles, then strobes the new row.
- R5: `cas_n` falls no sooner than `T_RCD` cycles after `ras_n` falls. An access pulse keeps `cas_n` low for exactly `T_CAS` cycles. `cas_n` stays high for at least `T_CP` cycles between pulses in one page.
- R6: During a write pulse, `we_n` is low, `oe_n` is high, `dq_oe` is high, and `dq_out` carries the host's write word.
- R7: During a read pulse, `we_n` is high and `oe_n` is low. The word on `dq_in` at the end of the pulse is returned on `rd_data` with `rd_valid` high for exactly one cycle, and reads complete in request order.
- R8: With the host idle, exactly one refresh occurs every `REF_WINDOW >> ROW_W` cycles.
- R9: A refresh closes any open row first. `cas_n` is low for at least `T_CSR` cycles before `ras_n` falls, and `we_n` stays high. After the refresh no row is open.
- R10: From the request until the end of a refresh, `req_ready` is low. A host request that waits during a refresh is served after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DW | Write word |
| rd_valid | output | 1 | One-cycle read return pulse |
| rd_data | output | DW | Read word |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | DW | Data driven to the DRAM |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | DW | Data read from the DRAM |

## Verification
The bench targets these cases:
- Back-to-back accesses within one row. A controller that forgot the open row would re-strobe the row each time, and the activation count would show it.
- Alternating rows. Here a missing or short precharge would show as a high-time below `T_RP`.
- An open row overtaken by refresh. If the controller did not close the row or kept stale hit state, it would strobe CAS-before-RAS without a precharge, or skip the activation on the next access.
- Long idle stretches, which expose a refresh interval miscounted by even one cycle.
- Random traffic mixed with refreshes. A request accepted during refresh, or a misrouted read word, would break the reference scoreboard.

// File: rtl/dram_pkg.sv
package dram_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_CP,
        ST_OPEN,
        ST_PRE,
        ST_RCSR,
        ST_RLOW,
        ST_RREC
    } seq_st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STB_QUIET = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    // load value for a down-counter so the state lasts n cycles
    function automatic logic [CNT_W-1:0] span(input int n);
        return (n <= 1) ? '0 : CNT_W'(n - 1);
    endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int ROW_W      = 10,
    parameter int REF_WINDOW = 262144
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_ack,
    output logic ref_pending
);
    localparam int REF_ROWS = 1 << ROW_W;
    localparam int INTERVAL = REF_WINDOW / REF_ROWS;
    localparam int TW       = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tick_q;
    logic          wrap;

    assign wrap = (tick_q == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q      <= '0;
            ref_pending <= 1'b0;
        end else begin
            tick_q <= wrap ? '0 : tick_q + 1'b1;
            if (wrap)
                ref_pending <= 1'b1;
            else if (ref_ack)
                ref_pending <= 1'b0;
        end
    end

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_pending && !ref_ack) |=> ref_pending);

endmodule

// File: rtl/dram_row_track.sv
module dram_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_go,
    input  logic [ROW_W-1:0] open_row,
    input  logic             close_go,
    input  logic [ROW_W-1:0] req_row,
    output logic             row_open,
    output logic             row_hit
);
    logic [ROW_W-1:0] held_row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open   <= 1'b0;
            held_row_q <= '0;
        end else if (close_go) begin
            row_open <= 1'b0;
        end else if (open_go) begin
            row_open   <= 1'b1;
            held_row_q <= open_row;
        end
    end

    assign row_hit = row_open && (req_row == held_row_q);

endmodule

// File: rtl/dram_seq.sv
module dram_seq import dram_pkg::*; #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int DW    = 16,
    parameter int T_RCD = 3,
    parameter int T_CAS = 2,
    parameter int T_CP  = 1,
    parameter int T_RP  = 3,
    parameter int T_CSR = 1,
    parameter int T_CBR = 4,
    localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_fire,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_we,
    input  logic [DW-1:0]    req_wdata,
    input  logic             ref_pending,
    input  logic             row_hit,
    output logic             can_take,
    output logic             ref_ack,
    output logic             open_go,
    output logic [ROW_W-1:0] open_row,
    output logic             close_go,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             oe_n,
    output logic [AW-1:0]    dram_addr,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    input  logic [DW-1:0]    dq_in,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             we;
        logic [DW-1:0]    data;
    } acc_t;

    seq_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             to_ref_q, to_ref_d;
    acc_t             cur_q, cur_d, in_acc;
    logic             done, cap;
    strobe_t          stb;

    assign in_acc   = '{row: req_row, col: req_col, we: req_we, data: req_wdata};
    assign done     = (cnt_q == '0);
    assign can_take = ((st_q == ST_IDLE) || (st_q == ST_OPEN)) && !ref_pending;

    // next-state and event logic
    always_comb begin
        st_d     = st_q;
        cnt_d    = done ? cnt_q : cnt_q - 1'b1;
        to_ref_d = to_ref_q;
        cur_d    = cur_q;
        ref_ack  = 1'b0;
        open_go  = 1'b0;
        open_row = cur_q.row;
        close_go = 1'b0;
        cap      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    st_d    = ST_RCSR;
                    cnt_d   = span(T_CSR);
                    ref_ack = 1'b1;
                end else if (req_fire) begin
                    cur_d    = in_acc;
                    st_d     = ST_ACT;
                    cnt_d    = span(T_RCD);
                    open_go  = 1'b1;
                    open_row = req_row;
                end
            end
            ST_ACT: begin
                if (done) begin
                    st_d  = ST_COL;
                    cnt_d = span(T_CAS);
                end
            end
            ST_COL: begin
                if (done) begin
                    st_d  = ST_CP;
                    cnt_d = span(T_CP);
                    cap   = !cur_q.we;
                end
            end
            ST_CP: begin
                if (done) st_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (ref_pending) begin
                    st_d     = ST_PRE;
                    cnt_d    = span(T_RP);
                    to_ref_d = 1'b1;
                    close_go = 1'b1;
                end else if (req_fire) begin
                    cur_d = in_acc;
                    if (row_hit) begin
                        st_d  = ST_COL;
                        cnt_d = span(T_CAS);
                    end else begin
                        st_d     = ST_PRE;
                        cnt_d    = span(T_RP);
                        to_ref_d = 1'b0;
                        close_go = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (done) begin
                    if (to_ref_q) begin
                        st_d    = ST_RCSR;
                        cnt_d   = span(T_CSR);
                        ref_ack = 1'b1;
                    end else begin
                        st_d     = ST_ACT;
                        cnt_d    = span(T_RCD);
                        open_go  = 1'b1;
                        open_row = cur_q.row;
                    end
                end
            end
            ST_RCSR: begin
                if (done) begin
                    st_d  = ST_RLOW;
                    cnt_d = span(T_CBR);
                end
            end
            ST_RLOW: begin
                if (done) begin
                    st_d  = ST_RREC;
                    cnt_d = span(T_RP);
                end
            end
            ST_RREC: begin
                if (done) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            to_ref_q <= 1'b0;
            cur_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            to_ref_q <= to_ref_d;
            cur_q    <= cur_d;
            rd_valid <= cap;
            if (cap) rd_data <= dq_in;
        end
    end

    // strobe and address decode from the registered state
    always_comb begin
        stb       = STB_QUIET;
        dram_addr = '0;
        dq_oe     = 1'b0;
        unique case (st_q)
            ST_ACT: begin
                stb.ras_n = 1'b0;
                dram_addr = AW'(cur_q.row);
            end
            ST_COL: begin
                stb.ras_n = 1'b0;
                stb.cas_n = 1'b0;
                stb.we_n  = !cur_q.we;
                stb.oe_n  = cur_q.we;
                dram_addr = AW'(cur_q.col);
                dq_oe     = cur_q.we;
            end
            ST_CP, ST_OPEN: stb.ras_n = 1'b0;
            ST_RCSR: stb.cas_n = 1'b0;
            ST_RLOW: begin
                stb.ras_n = 1'b0;
                stb.cas_n = 1'b0;
            end
            default: stb = STB_QUIET;
        endcase
    end

    assign ras_n  = stb.ras_n;
    assign cas_n  = stb.cas_n;
    assign we_n   = stb.we_n;
    assign oe_n   = stb.oe_n;
    assign dq_out = cur_q.data;

    // R9
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> ($past(!cas_n) && we_n));

    // R5
    cas_after_row_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !ras_n) |-> $past(!ras_n));

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/dram_pm_ctrl.sv
module dram_pm_ctrl #(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 10,
    parameter int DW         = 16,
    parameter int T_RCD      = 3,
    parameter int T_CAS      = 2,
    parameter int T_CP       = 1,
    parameter int T_RP       = 3,
    parameter int T_CSR      = 1,
    parameter int T_CBR      = 4,
    parameter int REF_WINDOW = 262144,
    localparam int AW        = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int HAW       = ROW_W + COL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_we,
    input  logic [HAW-1:0] req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic           ras_n,
    output logic           cas_n,
    output logic           we_n,
    output logic           oe_n,
    output logic [AW-1:0]  dram_addr,
    output logic [DW-1:0]  dq_out,
    output logic           dq_oe,
    input  logic [DW-1:0]  dq_in
);
    logic             ref_pending, ref_ack;
    logic             open_go, close_go, row_open, row_hit;
    logic [ROW_W-1:0] open_row, req_row;
    logic [COL_W-1:0] req_col;

    assign req_row = req_addr[HAW-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    dram_ref_timer #(.ROW_W(ROW_W), .REF_WINDOW(REF_WINDOW)) u_timer (
        .clk(clk), .rst(rst), .ref_ack(ref_ack), .ref_pending(ref_pending)
    );

    dram_row_track #(.ROW_W(ROW_W)) u_track (
        .clk(clk), .rst(rst), .open_go(open_go), .open_row(open_row),
        .close_go(close_go), .req_row(req_row), .row_open(row_open), .row_hit(row_hit)
    );

    dram_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR), .T_CBR(T_CBR)
    ) u_seq (
        .clk(clk), .rst(rst), .req_fire(req_valid && req_ready),
        .req_row(req_row), .req_col(req_col), .req_we(req_we), .req_wdata(req_wdata),
        .ref_pending(ref_pending), .row_hit(row_hit), .can_take(req_ready),
        .ref_ack(ref_ack), .open_go(open_go), .open_row(open_row), .close_go(close_go),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .dram_addr(dram_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ras_n && cas_n && we_n && oe_n && !row_open));

    // R3
    hit_keeps_row_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && row_hit && !ras_n) |=> !ras_n);

    // R4
    precharge_closes_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> !row_open);

    // R10
    ref_blocks_host_chk: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && ras_n) |-> !req_ready);

endmodule

// File: tb/tb_dram_pm_ctrl.sv
module tb_dram_pm_ctrl;
    localparam int ROW_W = 10, COL_W = 10, DW = 16;
    localparam int T_RCD = 3, T_CAS = 2, T_CP = 1, T_RP = 3, T_CSR = 1, T_CBR = 4;
    localparam int REF_WINDOW = 262144;
    localparam int INTERVAL = REF_WINDOW >> ROW_W;
    localparam int HAW = ROW_W + COL_W;
    localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst;
    logic           req_valid, req_ready, req_we;
    logic [HAW-1:0] req_addr;
    logic [DW-1:0]  req_wdata, rd_data, dq_out, dq_in;
    logic           rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [AW-1:0]  dram_addr;

    dram_pm_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
        .T_RP(T_RP), .T_CSR(T_CSR), .T_CBR(T_CBR), .REF_WINDOW(REF_WINDOW)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .dram_addr(dram_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int          row;
        int          col;
        bit          we;
        logic [15:0] data;
    } op_t;

    op_t         exp_q[$];
    logic [15:0] rd_q[$];
    logic [15:0] exp_mem[int];
    logic [15:0] dram_mem[int];

    function automatic logic [15:0] seed_val(input int a);
        return 16'(a * 37 + 16'h05a1);
    endfunction

    // behavioural DRAM and per-clock reference comparison
    int  cyc = 0, act_cnt = 0, cbr_cnt = 0;
    int  ras_hi_len = 100, cas_lo_len = 0, cas_hi_len = 100, t_ras_fall = 0;
    int  cur_row = 0;
    bit  p_ras = 1, p_cas = 1, in_cbr = 0;
    logic [15:0] dq_in_r = '0;
    assign dq_in = dq_in_r;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (p_ras && !ras_n) begin
                if (!cas_n) begin
                    cbr_cnt++;
                    in_cbr = 1;
                    check(cas_lo_len >= T_CSR, "R9", "cas lead before ras", cas_lo_len, T_CSR);
                    check(we_n == 1'b1, "R9", "we_n during refresh", we_n, 1);
                    check(ras_hi_len >= T_RP, "R9", "precharge before refresh", ras_hi_len, T_RP);
                    check(req_ready == 1'b0, "R10", "ready during refresh", req_ready, 0);
                end else begin
                    act_cnt++;
                    t_ras_fall = cyc;
                    cur_row = int'(dram_addr);
                    check(ras_hi_len >= T_RP, "R4", "ras high time", ras_hi_len, T_RP);
                    if (exp_q.size() == 0)
                        check(0, "R2", "row strobe with nothing queued", dram_addr, 0);
                    else
                        check(int'(dram_addr) == exp_q[0].row, "R2", "row address",
                              dram_addr, exp_q[0].row);
                end
            end
            if (p_cas && !cas_n && !ras_n && !p_ras) begin
                check(cyc - t_ras_fall >= T_RCD, "R5", "ras to cas", cyc - t_ras_fall, T_RCD);
                check(cas_hi_len >= T_CP, "R5", "cas precharge", cas_hi_len, T_CP);
                if (exp_q.size() == 0) begin
                    check(0, "R2", "column strobe with nothing queued", dram_addr, 0);
                end else begin
                    op_t o;
                    int  key;
                    o = exp_q.pop_front();
                    check(int'(dram_addr) == o.col, "R2", "column address", dram_addr, o.col);
                    check(cur_row == o.row, "R3", "open row used", cur_row, o.row);
                    check(we_n == !o.we, "R6", "we_n", we_n, !o.we);
                    check(oe_n == o.we, "R7", "oe_n", oe_n, o.we);
                    key = (cur_row << COL_W) | int'(dram_addr);
                    if (o.we) begin
                        check(dq_oe == 1'b1, "R6", "dq_oe", dq_oe, 1);
                        check(dq_out == o.data, "R6", "write data", dq_out, o.data);
                        dram_mem[key] = dq_out;
                    end else begin
                        dq_in_r = dram_mem.exists(key) ? dram_mem[key] : seed_val(key);
                    end
                end
            end
            if (!p_cas && cas_n) begin
                if (!in_cbr)
                    check(cas_lo_len == T_CAS, "R5", "cas pulse width", cas_lo_len, T_CAS);
                in_cbr = 0;
            end
            if (rd_valid) begin
                if (rd_q.size() == 0)
                    check(0, "R7", "unexpected read return", rd_data, 0);
                else begin
                    logic [15:0] e;
                    e = rd_q.pop_front();
                    check(rd_data == e, "R7", "read data", rd_data, e);
                end
            end
        end
        ras_hi_len = ras_n ? ras_hi_len + 1 : 0;
        cas_lo_len = !cas_n ? cas_lo_len + 1 : 0;
        cas_hi_len = cas_n ? cas_hi_len + 1 : 0;
        p_ras = ras_n;
        p_cas = cas_n;
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired, all requirements unfinished");
            summary();
            $finish;
        end
    end

    task automatic host_op(input bit we, input int a, input logic [15:0] d);
        op_t o;
        o.row = a >> COL_W;
        o.col = a & ((1 << COL_W) - 1);
        o.we = we;
        o.data = d;
        exp_q.push_back(o);
        if (we) exp_mem[a] = d;
        else rd_q.push_back(exp_mem.exists(a) ? exp_mem[a] : seed_val(a));
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = HAW'(a);
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_cbr();
        int c;
        c = cbr_cnt;
        while (cbr_cnt == c) @(negedge clk);
    endtask

    initial begin
        int a0, c0, lcg;
        rst = 1'b1;
        req_valid = 1'b0;
        req_we = 1'b0;
        req_addr = '0;
        req_wdata = '0;
        repeat (5) @(negedge clk);
        check({ras_n, cas_n, we_n, oe_n} == 4'hf, "R1", "strobes in reset", {ras_n, cas_n, we_n, oe_n}, 4'hf);
        rst = 1'b0;
        @(negedge clk);
        check({ras_n, cas_n, we_n, oe_n} == 4'hf, "R1", "strobes after reset", {ras_n, cas_n, we_n, oe_n}, 4'hf);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

        // first access after reset must open a row; write then read back
        a0 = act_cnt;
        host_op(1, 'h00410, 16'hBEEF);
        host_op(0, 'h00410, 16'h0);
        host_op(0, 'h00411, 16'h0);
        drain();
        check(act_cnt - a0 == 1, "R1", "activations after reset", act_cnt - a0, 1);

        // R3: page hits within row 5
        wait_cbr();
        a0 = act_cnt;
        host_op(1, (5 << COL_W) | 1, 16'h1111);
        host_op(0, (5 << COL_W) | 7, 16'h0);
        host_op(1, (5 << COL_W) | 2, 16'h2222);
        host_op(0, (5 << COL_W) | 1, 16'h0);
        drain();
        check(act_cnt - a0 == 1, "R3", "activations for same row", act_cnt - a0, 1);

        // R4: page misses
        wait_cbr();
        a0 = act_cnt;
        host_op(0, (7 << COL_W), 16'h0);
        host_op(0, (8 << COL_W), 16'h0);
        host_op(1, (9 << COL_W) | 3, 16'h3333);
        drain();
        check(act_cnt - a0 == 3, "R4", "activations for three rows", act_cnt - a0, 3);

        // mixed traffic interleaved with refresh (R2, R6, R7, R10)
        lcg = 12345;
        for (int i = 0; i < 80; i++) begin
            int addr;
            lcg = lcg * 1103515245 + 12345;
            addr = (((lcg >>> 8) & 3) << COL_W) | ((lcg >>> 12) & 15);
            host_op(((lcg >>> 20) & 1) == 1, addr, 16'(lcg >>> 4));
            if (((lcg >>> 24) & 7) == 0) repeat (INTERVAL / 4) @(negedge clk);
        end
        drain();

        // R8: refresh cadence with host idle
        repeat (2 * INTERVAL) @(negedge clk);
        c0 = cbr_cnt;
        repeat (8 * INTERVAL) @(negedge clk);
        check(cbr_cnt - c0 == 8, "R8", "refreshes in eight intervals", cbr_cnt - c0, 8);

        // R9: refresh closes an open row, next access re-activates it
        wait_cbr();
        host_op(0, (3 << COL_W) | 5, 16'h0);
        drain();
        wait_cbr();
        repeat (T_CBR + T_RP + 2) @(negedge clk);
        a0 = act_cnt;
        host_op(0, (3 << COL_W) | 6, 16'h0);
        drain();
        check(act_cnt - a0 == 1, "R9", "row reopened after refresh", act_cnt - a0, 1);

        check(exp_q.size() == 0, "R7", "accesses left over", exp_q.size(), 0);
        check(rd_q.size() == 0, "R7", "reads left over", rd_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end

endmodule